// File: doc/BRIEF.md
# Chip Reset Conditioner

This block gathers every reason the chip should be in reset and produces one synchronous, active-high chip reset. It takes three sources. The first is an active-low external reset pin. The second is a low-supply flag from an analog comparator. The third is a reset request from the watchdog. Both asynchronous inputs, the pin and the low-supply flag, pass through a synchroniser chain before any logic uses them.

The pin is filtered by width. A low level on the pin becomes a reset only after it has been seen for a minimum number of consecutive system clocks. A shorter glitch clears the width counter and leaves the reset output alone. Once any source is active, the output is held asserted for as long as that source stays active. After the source goes away, the output stays asserted for a fixed stretch period. In silicon this period is in the order of 150 ms. Here it is a cycle-count parameter, so simulation can use a small value.

A new source that arrives during a stretch restarts the count from zero. Leaving power-on reset behaves like one stretch period with no source present.

Top module: `reset_merge_top`

## Requirements
- R1: The pin and the low-supply flag each pass through SYNC_STAGES (default 2) flops. With the defaults, a pin driven low just before clock edge 1 and held low asserts `sys_rst_o` after edge SYNC_STAGES+MIN_LOW+1, which is edge 13, and not before it.
- R2: A pin low for MIN_LOW (default 10) consecutive clocks or longer is a valid reset request. `sys_rst_o` stays asserted for as long as the pin stays low.
- R3: A pin low for fewer than MIN_LOW clocks has no effect. `sys_rst_o` stays low if it was low, and an ongoing stretch is not restarted.
- R4: After a qualified pin returns high, `sys_rst_o` deasserts after exactly HOLD_CYCLES+SYNC_STAGES+1 clock edges.
- R5: While `lowv_i` is high, `sys_rst_o` is asserted continuously. It rises SYNC_STAGES+1 edges after `lowv_i` rises.
- R6: After `lowv_i` falls, `sys_rst_o` deasserts after exactly HOLD_CYCLES+SYNC_STAGES edges.
- R7: A `wdog_req_i` pulse of one cycle asserts `sys_rst_o` at the next edge. The output releases HOLD_CYCLES edges after the pulse ends.
- R8: A source that becomes active during a stretch restarts the stretch count from zero.
- R9: While `por_n` is low, `sys_rst_o` is high. After `por_n` releases with no source active, `sys_rst_o` stays high for exactly HOLD_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of this block, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lowv_i | input | 1 | Low-supply flag from the comparator, active high, asynchronous |
| wdog_req_i | input | 1 | Watchdog reset request, synchronous to clk, active high |
| sys_rst_o | output | 1 | Chip-wide synchronous reset, active high |

## Verification
The assertions take `wdog_req_i` to be synchronous to `clk`. They also take `por_n` to be held low from time zero until the inputs settle: the pin high, the low-supply flag low and the watchdog idle. The watchdog and low-supply properties compare sampled input levels against the output one edge later. They therefore rely on inputs changing only between edges. The stimulus drives every input on the falling clock edge. It starts each scenario only after the previous release has been seen.

// File: rtl/reset_pkg.sv
package reset_pkg;

    // one bit per reset cause after synchronisation and qualification
    typedef struct packed {
        logic pin;
        logic lowv;
        logic wdog;
    } rst_src_t;

    function automatic logic any_src(input rst_src_t s);
        return s.pin | s.lowv | s.wdog;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{sh: {STAGES{RST_VAL}}};
        else         st_q <= st_d;
    end

    assign dout = st_q.sh[STAGES-1];
endmodule

// File: rtl/pin_width_qual.sv
module pin_width_qual #(
    parameter int MIN_LOW = 10
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_s,
    output logic valid_o
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_LOW);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pin_s)                st_d.cnt = '0;
        else if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{cnt: '0};
        else         st_q <= st_d;
    end

    assign valid_o = (st_q.cnt == FULL);
endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
    parameter int HOLD_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold_i,
    output logic rst_o
);
    localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          rst;
        logic [HW-1:0] cnt;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.rst = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.rst) begin
            if (st_q.cnt == LAST) begin
                st_d.rst = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '{rst: 1'b1, cnt: '0};
        else         st_q <= st_d;
    end

    assign rst_o = st_q.rst;
endmodule

// File: rtl/reset_merge_top.sv
module reset_merge_top
    import reset_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 10,
    parameter int HOLD_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_n,
    input  logic lowv_i,
    input  logic wdog_req_i,
    output logic sys_rst_o
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_raw;
    logic [N_ASYNC-1:0] async_s;
    rst_src_t           src;

    assign async_raw = {lowv_i, ext_rst_n};

    // index 0 idles high (pin), index 1 idles low (flag)
    for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
        sync_chain #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL ((i == 0) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk    (clk),
            .arst_n (por_n),
            .din    (async_raw[i]),
            .dout   (async_s[i])
        );
    end

    pin_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .arst_n  (por_n),
        .pin_s   (async_s[0]),
        .valid_o (src.pin)
    );

    assign src.lowv = async_s[1];
    assign src.wdog = wdog_req_i;

    reset_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk    (clk),
        .arst_n (por_n),
        .hold_i (any_src(src)),
        .rst_o  (sys_rst_o)
    );
endmodule

// File: rtl/reset_merge_chk.sv
module reset_merge_chk #(
    parameter int HOLD_CYCLES = 1_200_000
) (
    input logic clk,
    input logic por_n,
    input logic lowv_i,
    input logic wdog_req_i,
    input logic sys_rst_o
);
    localparam int PW = $clog2(HOLD_CYCLES + 1);
    localparam logic [PW-1:0] PMAX = PW'(HOLD_CYCLES);

    logic [PW-1:0] since_por;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 since_por <= '0;
        else if (since_por != PMAX) since_por <= since_por + 1'b1;
    end

    // R7
    wdog_asserts_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdog_req_i |=> sys_rst_o);

    // R5
    lowv_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
        (lowv_i && $past(lowv_i) && $past(lowv_i, 2)) |=> sys_rst_o);

    // R8
    no_release_on_wdog_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_o) |-> !$past(wdog_req_i));

    // R9
    powerup_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (since_por < PMAX) |-> sys_rst_o);
endmodule

bind reset_merge_top reset_merge_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
    .clk        (clk),
    .por_n      (por_n),
    .lowv_i     (lowv_i),
    .wdog_req_i (wdog_req_i),
    .sys_rst_o  (sys_rst_o)
);

// File: tb/reset_merge_top_tb_top.sv
`timescale 1ns/1ps
module reset_merge_top_tb_top;
    localparam int SYNC = 2;
    localparam int MINL = 10;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst_n = 1'b1;
    logic lowv_i = 1'b0;
    logic wdog_req_i = 1'b0;
    logic sys_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    reset_merge_top #(.SYNC_STAGES(SYNC), .MIN_LOW(MINL), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .lowv_i(lowv_i), .wdog_req_i(wdog_req_i), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts falling edges until sys_rst_o reads low, starting from n0
    task automatic wait_release(input int n0, output int n);
        n = n0;
        do begin
            @(negedge clk);
            n++;
        end while (sys_rst_o && n < 5000);
    endtask

    task automatic t_powerup;
        int n;
        repeat (3) @(negedge clk);
        chk(sys_rst_o == 1'b1, "R9 held in por", sys_rst_o, 1);
        por_n = 1'b1;
        wait_release(0, n);
        chk(n == HOLD, "R9 powerup release", n, HOLD);
    endtask

    task automatic t_short_pulse;
        int highs = 0;
        ext_rst_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (sys_rst_o) highs++;
        end
        chk(highs == 0, "R3 short pulse ignored", highs, 0);
    endtask

    task automatic t_exact_pulse;
        int n;
        ext_rst_n = 1'b0;
        repeat (MINL) @(negedge clk);
        ext_rst_n = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(sys_rst_o == 1'b0, "R1 not before edge 13", sys_rst_o, 0);
        @(negedge clk);
        chk(sys_rst_o == 1'b1, "R2 min width accepted", sys_rst_o, 1);
        wait_release(SYNC + 1, n);
        chk(n == HOLD + SYNC + 1, "R4 release after min pulse", n, HOLD + SYNC + 1);
    endtask

    task automatic t_long_pulse;
        int n;
        int lows = 0;
        ext_rst_n = 1'b0;
        repeat (SYNC + MINL) @(negedge clk);
        chk(sys_rst_o == 1'b0, "R1 latency low side", sys_rst_o, 0);
        @(negedge clk);
        chk(sys_rst_o == 1'b1, "R1 latency rise", sys_rst_o, 1);
        repeat (HOLD + 20) begin
            @(negedge clk);
            if (!sys_rst_o) lows++;
        end
        chk(lows == 0, "R2 held while pin low", lows, 0);
        ext_rst_n = 1'b1;
        wait_release(0, n);
        chk(n == HOLD + SYNC + 1, "R4 release after long pulse", n, HOLD + SYNC + 1);
    endtask

    task automatic t_lowv;
        int n;
        int lows = 0;
        lowv_i = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(sys_rst_o == 1'b0, "R5 not before sync", sys_rst_o, 0);
        @(negedge clk);
        chk(sys_rst_o == 1'b1, "R5 rise", sys_rst_o, 1);
        repeat (2 * HOLD) begin
            @(negedge clk);
            if (!sys_rst_o) lows++;
        end
        chk(lows == 0, "R5 continuous hold", lows, 0);
        lowv_i = 1'b0;
        wait_release(0, n);
        chk(n == HOLD + SYNC, "R6 release after lowv", n, HOLD + SYNC);
    endtask

    task automatic t_wdog;
        int n;
        wdog_req_i = 1'b1;
        @(negedge clk);
        wdog_req_i = 1'b0;
        chk(sys_rst_o == 1'b1, "R7 wdog assert", sys_rst_o, 1);
        wait_release(0, n);
        chk(n == HOLD, "R7 wdog release", n, HOLD);
    endtask

    task automatic t_restart;
        int n;
        wdog_req_i = 1'b1;
        @(negedge clk);
        wdog_req_i = 1'b0;
        repeat (15) @(negedge clk);
        // a short pin glitch mid-stretch must not extend it
        ext_rst_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        ext_rst_n = 1'b1;
        wait_release(15 + MINL - 1, n);
        chk(n == HOLD, "R3 glitch during stretch", n, HOLD);
        wdog_req_i = 1'b1;
        @(negedge clk);
        wdog_req_i = 1'b0;
        repeat (20) @(negedge clk);
        wdog_req_i = 1'b1;
        @(negedge clk);
        wdog_req_i = 1'b0;
        wait_release(0, n);
        chk(n == HOLD, "R8 stretch restarted", n, HOLD);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_powerup();
        t_short_pulse();
        t_exact_pulse();
        t_long_pulse();
        t_lowv();
        t_wdog();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule